// File: doc/BRIEF.md
# Programmable Terminal-Count Rate Divider

The block turns a free-running clock into a periodic clock-enable. A loadable synchronous counter, 20 bits wide by default, is reloaded from a programmable divisor register each time it reaches its terminal state. The terminal condition is captured in a flip-flop. That flop's output is the block's only output, a pulse one clock wide. The same registered flag also requests the synchronous reload. Downstream logic uses the pulse as an enable, and it arrives once every divisor+1 clocks.

Two terminal-count schemes are built in, and the `count_up` input selects between them. In down mode the counter is loaded with the divisor and counts toward one. In up mode it is loaded with the bitwise inverse of the divisor and counts toward all ones. The up-mode terminal test is the increment's carry chain, not an equality compare against an arbitrary value. Both schemes give exactly the same pulse timing. The divisor can be rewritten at any time, and the new value is picked up cleanly at the next reload.

Top module: `tc_rate_divider`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after that edge, `tick` is 0. Reset reloads the counter at the first edge with `rst` low. The first pulse appears D+1 edges after the last reset edge, where D is the effective divisor.
- R2: `tick` is never high in two consecutive cycles. With a divisor of 1 it alternates high and low.
- R3: With `count_up` = 0 (down mode), `tick` rises every D+1 cycles. The counter holds the divisor after a reload and holds zero while the pulse is high.
- R4: With `count_up` = 1 (up mode), the counter is reloaded with the inverse of the divisor. The pulse coincides with the counter at all ones, and the period is D+1, identical to down mode.
- R5: A stored divisor of 0 behaves as 1, which gives a period of 2 cycles.
- R6: A divisor write (`div_we` = 1 with `div_data`) is used from the next reload. A period already running keeps its length. A write sampled on the same edge as a reload is not used by that reload, only by the one after.
- R7: `count_up` is sampled only at a reload edge. Toggling it at any other time has no effect on the pulse timing.
- R8: Reset sets the divisor register to the parameter `DIV_INIT`. A write presented while `rst` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| div_we | input | 1 | Divisor write strobe |
| div_data | input | W | Divisor value to store |
| count_up | input | 1 | Counting scheme: 0 = down toward one, 1 = up toward all ones |
| tick | output | 1 | Registered enable pulse, one cycle wide |

## Verification
Two events can fall on the same edge: a divisor write and the reload of the counter. The bench provokes this by waiting until `tick` is high and presenting a write during that cycle, so the write and the reload share one edge. It judges the result by requiring that the following period still uses the old divisor and only the period after it uses the new one. A reset asserted together with a write is judged the same way, with the reset winning and `DIV_INIT` governing the first period.

// File: rtl/tcdiv_pkg.sv
package tcdiv_pkg;
  typedef enum logic {
    CNT_DOWN = 1'b0,
    CNT_UP   = 1'b1
  } cnt_dir_e;

  localparam int DEF_W = 20;
endpackage

// File: rtl/tcdiv_divreg.sv
module tcdiv_divreg #(
  parameter int W = 20,
  parameter logic [W-1:0] DIV_INIT = W'(1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] div_eff
);
  logic [W-1:0] div_q;

  // Writes during reset are dropped; reset restores the default divisor.
  always_ff @(posedge clk) begin
    if (rst)     div_q <= DIV_INIT;
    else if (we) div_q <= wdata;
  end

  // A zero divisor is promoted to one so the counter never idles.
  always_comb begin
    if (div_q == '0) div_eff = W'(1);
    else             div_eff = div_q;
  end
endmodule

// File: rtl/tcdiv_counter.sv
module tcdiv_counter
  import tcdiv_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] div_val,
  input  cnt_dir_e     dir_in,
  output logic [W-1:0] cnt,
  output cnt_dir_e     dir_q
);
  logic [W-1:0] load_val;

  always_comb begin
    if (dir_in == CNT_UP) load_val = ~div_val;
    else                  load_val = div_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dir_q <= CNT_DOWN;
    end else if (load) begin
      cnt   <= load_val;
      dir_q <= dir_in;
    end else if (dir_q == CNT_UP) begin
      cnt   <= cnt + W'(1);
    end else begin
      cnt   <= cnt - W'(1);
    end
  end

  // Direction is frozen between reloads.
  p_dir_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dir_q));

  // A down-mode reload never lands on zero.
  p_dn_load_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    (load && dir_in == CNT_DOWN) |=> (cnt != '0));
endmodule

// File: rtl/tcdiv_tc_detect.sv
module tcdiv_tc_detect
  import tcdiv_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  cnt_dir_e     dir_q,
  output logic         load,
  output logic         pulse
);
  logic init_q;
  logic pre_term;
  logic hi_zero;
  logic hi_ones;

  // Upper-bit reductions: an up-count carry chain, or a down-count zero test.
  assign hi_ones = &cnt[W-1:1];
  assign hi_zero = ~|cnt[W-1:1];

  // Fire one state early so the registered flag lines up with the terminal state.
  always_comb begin
    if (dir_q == CNT_UP) pre_term = hi_ones & ~cnt[0];
    else                 pre_term = hi_zero &  cnt[0];
  end

  assign load = pulse | init_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      init_q <= 1'b1;
    end else begin
      pulse  <= pre_term & ~load;
      init_q <= 1'b0;
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pulse);
endmodule

// File: rtl/tc_rate_divider.sv
module tc_rate_divider
  import tcdiv_pkg::*;
#(
  parameter int W = DEF_W,
  parameter logic [W-1:0] DIV_INIT = W'(4)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         div_we,
  input  logic [W-1:0] div_data,
  input  logic         count_up,
  output logic         tick
);
  logic [W-1:0] div_eff;
  logic [W-1:0] cnt;
  cnt_dir_e     dir_q;
  cnt_dir_e     dir_in;
  logic         load;

  assign dir_in = count_up ? CNT_UP : CNT_DOWN;

  tcdiv_divreg #(.W(W), .DIV_INIT(DIV_INIT)) u_div (
    .clk(clk), .rst(rst), .we(div_we), .wdata(div_data), .div_eff(div_eff)
  );

  tcdiv_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .div_val(div_eff),
    .dir_in(dir_in), .cnt(cnt), .dir_q(dir_q)
  );

  tcdiv_tc_detect #(.W(W)) u_tc (
    .clk(clk), .rst(rst), .cnt(cnt), .dir_q(dir_q),
    .load(load), .pulse(tick)
  );

  p_dn_term_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && dir_q == CNT_DOWN) |-> (cnt == '0));

  p_up_term_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && dir_q == CNT_UP) |-> (&cnt));
endmodule

// File: tb/sim_tc_rate_divider.sv
`timescale 1ns/1ps
module sim_tc_rate_divider;
  localparam int W = 20;
  localparam logic [W-1:0] INIT_DIV = W'(5);

  logic         clk = 1'b0;
  logic         rst_i = 1'b1;
  logic         we_i = 1'b0;
  logic [W-1:0] wd_i = '0;
  logic         mode_i = 1'b0;
  logic         tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Reference model state
  logic [W-1:0] m_div = INIT_DIV;
  int  m_rem = 0;
  bit  m_lp = 1'b0;
  bit  m_tick = 1'b0;

  always #4 clk = ~clk;

  tc_rate_divider #(.W(W), .DIV_INIT(INIT_DIV)) u0 (
    .clk(clk), .rst(rst_i), .div_we(we_i), .div_data(wd_i),
    .count_up(mode_i), .tick(tick)
  );

  function automatic int eff_div(input logic [W-1:0] d);
    return (d == '0) ? 1 : int'(d);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t tick actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // One clock: model the edge, then compare the registered output.
  task automatic cyc();
    @(posedge clk);
    if (rst_i) begin
      m_div = INIT_DIV; m_lp = 1'b1; m_tick = 1'b0; m_rem = 0;
    end else begin
      if (m_lp) begin
        m_rem = eff_div(m_div); m_lp = 1'b0; m_tick = 1'b0;
      end else begin
        m_rem--;
        m_tick = (m_rem == 0);
        if (m_rem == 0) m_lp = 1'b1;
      end
      if (we_i) m_div = wd_i;
    end
    #2;
    check(cur_req, tick, m_tick);
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [W-1:0] d);
    we_i = 1'b1; wd_i = d;
    cyc();
  endtask

  task automatic wait_tick();
    int guard = 0;
    while (!m_tick && guard < 5000) begin cyc(); guard++; end
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1";
    rst_i = 1'b1;
    run(3);
    rst_i = 1'b0;
    run(20);                                 // R1: first pulse D+1 after reset

    cur_req = "R3"; mode_i = 1'b0;
    wr(W'(3)); run(30);                      // R3: down mode period
    wr(W'(17)); run(60);

    cur_req = "R4"; mode_i = 1'b1;
    run(40);                                 // R4: up mode period
    wr(W'(9)); run(40);
    wr(W'(1000)); run(2100);

    cur_req = "R2"; wr(W'(1)); run(20);      // R2: alternate with divisor 1
    mode_i = 1'b0; run(20);

    cur_req = "R5"; wr(W'(0)); run(20);      // R5: zero behaves as one
    mode_i = 1'b1; run(20);

    cur_req = "R6"; wr(W'(12)); run(5);
    wait_tick(); run(3); wr(W'(4)); run(30); // R6: mid-period write
    wait_tick(); wr(W'(20)); run(60);        // R6: write on reload edge
    mode_i = 1'b0;
    wait_tick(); wr(W'(6)); run(50);

    cur_req = "R7"; wr(W'(25)); run(40);     // R7: toggle mode mid-period
    for (int i = 0; i < 120; i++) begin
      mode_i = ~mode_i;
      cyc();
    end

    cur_req = "R8"; wr(W'(11)); run(30);     // R8: reset with write ignored
    rst_i = 1'b1; we_i = 1'b1; wd_i = W'(2);
    cyc();
    rst_i = 1'b0; run(40);

    cur_req = "R3";                          // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      int r = int'($urandom % 100);
      if (r < 4) begin we_i = 1'b1; wd_i = W'($urandom % 40); end
      if (r >= 4 && r < 10) mode_i = ~mode_i;
      if (r == 99) rst_i = 1'b1;
      cyc();
      rst_i = 1'b0;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule